// File: doc/BRIEF.md
# Prioritized Interrupt Level Selector

This block sits between an interrupt controller and a processor core. Each cycle it looks at a 16-bit vector of pending external interrupt levels. It also holds a registered trap-type value that the core reads. When the held value is empty or already names an external interrupt, the block finds the highest pending level, encodes it as an external-interrupt trap type, and raises a hard-interrupt request if that type differs from the one it held.

A synchronous exception reported by the core takes the held slot. Once it is there, no change on the level vector disturbs it until the core acknowledges trap entry. The acknowledge empties the slot and drops the request, and the pending levels are looked at again on the following cycle. Both outputs are registered, so they move one clock after the inputs that cause the change.

Top module: `irq_level_sel`

## Requirements
- R1: Under reset (`rst_n` low) the trap type is 0x00 and the request is low.
- R2: Bits 15 down to 1 of the level vector are scanned and the highest set bit wins. Its level L is encoded as trap type 0x10 | L, so the range is 0x11 to 0x1F. It appears on `tt_o` one cycle after the vector is applied, provided the held value is 0x00 or in 0x10 to 0x1F.
- R3: The request goes high in the cycle the held type changes to a newly selected external type. It stays high while the selected type is unchanged.
- R4: When the whole level vector is zero and the held type is in 0x10 to 0x1F, the next cycle shows trap type 0x00 with the request low.
- R5: A level vector whose only set bit is bit 0 leaves the trap type and the request unchanged.
- R6: A synchronous exception is loaded when `sync_valid_i` is high and the held type is 0x00 or external. Its type must be non-zero and outside 0x10 to 0x1F. It appears on `tt_o` the next cycle, takes precedence over the level vector in the same cycle, and leaves the request unchanged.
- R7: While a synchronous trap type is held, neither the level vector nor further synchronous reports change the trap type or the request.
- R8: A high `ack_i` clears the trap type to 0x00 and the request to low on the next cycle, over every other input. Pending levels are then re-evaluated on the cycle after that.
- R9: A synchronous report whose type is 0x00 or lies in 0x10 to 0x1F is ignored, and level evaluation proceeds as if no report were made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| level_i | input | 16 | Pending external interrupt levels, bit n = level n |
| sync_valid_i | input | 1 | A synchronous exception is reported this cycle |
| sync_tt_i | input | 8 | Trap type of the reported synchronous exception |
| ack_i | input | 1 | Core has entered the trap; empty the held slot |
| tt_o | output | 8 | Held trap type |
| req_o | output | 1 | Hard-interrupt request |

## Verification
The bench walks a vector with only bit 0 set over both an empty and an external slot. A design that treats bit 0 as an interrupt or as an empty vector would then show 0x10 or clear the slot. It raises the level vector while a synchronous type is held, and a design without the guard would overwrite the exception with 0x1F. It raises acknowledge and a synchronous report in the same cycle, where a wrong priority leaves a non-zero type. It feeds synchronous reports whose types fall in the external range, which a design without the validity check would store as a false interrupt. It also checks that a lower level arriving under a higher one changes nothing.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

    localparam int          LEVELS_DEF   = 16;
    localparam int          TT_W_DEF     = 8;
    localparam logic [7:0]  EXT_BASE_DEF = 8'h10;

    // kind of value held in the trap-type slot
    typedef enum logic [1:0] {
        TT_EMPTY = 2'd0,
        TT_EXT   = 2'd1,
        TT_SYNC  = 2'd2
    } tt_class_e;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int LEVELS = 16,
    parameter int LVL_W  = $clog2(LEVELS)
) (
    input  logic [LEVELS-1:1] lvl_hi_i,
    output logic              any_o,
    output logic [LVL_W-1:0]  idx_o
);

    logic [LEVELS:1]   above;
    logic [LEVELS-1:1] grant;

    assign above[LEVELS] = 1'b0;

    // one stage per level: a level wins only if nothing above it is set
    for (genvar i = LEVELS - 1; i >= 1; i--) begin : g_stage
        assign above[i] = above[i+1] | lvl_hi_i[i];
        assign grant[i] = lvl_hi_i[i] & ~above[i+1];
    end

    assign any_o = above[1];

    always_comb begin
        idx_o = '0;
        for (int i = 1; i < LEVELS; i++) begin
            if (grant[i]) idx_o = idx_o | LVL_W'(i);
        end
    end

endmodule

// File: rtl/irq_tt_class.sv
module irq_tt_class
    import irq_sel_pkg::*;
#(
    parameter int             TT_W     = 8,
    parameter int             LVL_W    = 4,
    parameter logic [TT_W-1:0] EXT_BASE = 8'h10
) (
    input  logic [TT_W-1:0] tt_i,
    output tt_class_e       cls_o
);

    logic upper_ext;

    assign upper_ext = (tt_i[TT_W-1:LVL_W] == EXT_BASE[TT_W-1:LVL_W]);

    always_comb begin
        if (tt_i == '0)     cls_o = TT_EMPTY;
        else if (upper_ext) cls_o = TT_EXT;
        else                cls_o = TT_SYNC;
    end

endmodule

// File: rtl/irq_level_sel.sv
module irq_level_sel
    import irq_sel_pkg::*;
#(
    parameter int              LEVELS   = LEVELS_DEF,
    parameter int              TT_W     = TT_W_DEF,
    parameter logic [TT_W-1:0] EXT_BASE = EXT_BASE_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEVELS-1:0] level_i,
    input  logic              sync_valid_i,
    input  logic [TT_W-1:0]   sync_tt_i,
    input  logic              ack_i,
    output logic [TT_W-1:0]   tt_o,
    output logic              req_o
);

    localparam int LVL_W = $clog2(LEVELS);

    typedef struct packed {
        logic [TT_W-1:0] tt;
        logic            req;
    } sel_state_t;

    sel_state_t st_d, st_q;

    logic             lvl_any;
    logic [LVL_W-1:0] lvl_idx;
    logic [TT_W-1:0]  cand_tt;
    tt_class_e        held_cls;
    tt_class_e        sync_cls;

    irq_prio_enc #(
        .LEVELS (LEVELS),
        .LVL_W  (LVL_W)
    ) u_enc (
        .lvl_hi_i (level_i[LEVELS-1:1]),
        .any_o    (lvl_any),
        .idx_o    (lvl_idx)
    );

    irq_tt_class #(
        .TT_W     (TT_W),
        .LVL_W    (LVL_W),
        .EXT_BASE (EXT_BASE)
    ) u_held_cls (
        .tt_i  (st_q.tt),
        .cls_o (held_cls)
    );

    irq_tt_class #(
        .TT_W     (TT_W),
        .LVL_W    (LVL_W),
        .EXT_BASE (EXT_BASE)
    ) u_sync_cls (
        .tt_i  (sync_tt_i),
        .cls_o (sync_cls)
    );

    assign cand_tt = {EXT_BASE[TT_W-1:LVL_W], lvl_idx};

    always_comb begin
        st_d = st_q;
        if (ack_i) begin
            st_d = '0;
        end else if (held_cls != TT_SYNC) begin
            if (sync_valid_i && sync_cls == TT_SYNC) begin
                st_d.tt = sync_tt_i;
            end else if (lvl_any) begin
                if (cand_tt != st_q.tt) begin
                    st_d.tt  = cand_tt;
                    st_d.req = 1'b1;
                end
            end else if (!level_i[0] && held_cls == TT_EXT) begin
                st_d = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tt_o  = st_q.tt;
    assign req_o = st_q.req;

endmodule

// File: rtl/irq_level_sel_chk.sv
module irq_level_sel_chk #(
    parameter int              LEVELS   = 16,
    parameter int              TT_W     = 8,
    parameter logic [TT_W-1:0] EXT_BASE = 8'h10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LEVELS-1:0] level_i,
    input logic              sync_valid_i,
    input logic [TT_W-1:0]   sync_tt_i,
    input logic              ack_i,
    input logic [TT_W-1:0]   tt_o,
    input logic              req_o
);

    localparam int LVL_W = $clog2(LEVELS);

    logic held_ext, held_sync, sync_ok;

    assign held_ext  = (tt_o[TT_W-1:LVL_W] == EXT_BASE[TT_W-1:LVL_W]);
    assign held_sync = (tt_o != '0) && !held_ext;
    assign sync_ok   = (sync_tt_i != '0) &&
                       (sync_tt_i[TT_W-1:LVL_W] != EXT_BASE[TT_W-1:LVL_W]);

    p_ext_level_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        held_ext |-> tt_o[LVL_W-1:0] != '0);

    p_req_rise_on_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> tt_o != $past(tt_o));

    p_drop_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (held_ext && !ack_i && level_i == '0 && !(sync_valid_i && sync_ok))
        |=> (tt_o == '0 && !req_o));

    p_bit0_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (level_i[LEVELS-1:1] == '0 && level_i[0] && !ack_i && !sync_valid_i)
        |=> ($stable(tt_o) && $stable(req_o)));

    p_sync_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (held_sync && !ack_i) |=> ($stable(tt_o) && $stable(req_o)));

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> (tt_o == '0 && !req_o));

endmodule

bind irq_level_sel irq_level_sel_chk #(
    .LEVELS   (LEVELS),
    .TT_W     (TT_W),
    .EXT_BASE (EXT_BASE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .level_i      (level_i),
    .sync_valid_i (sync_valid_i),
    .sync_tt_i    (sync_tt_i),
    .ack_i        (ack_i),
    .tt_o         (tt_o),
    .req_o        (req_o)
);

// File: tb/sim_irq_level_sel.sv
`timescale 1ns/1ps
module sim_irq_level_sel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] level_i = '0;
    logic        sync_valid_i = 1'b0;
    logic [7:0]  sync_tt_i = '0;
    logic        ack_i = 1'b0;
    logic [7:0]  tt_o;
    logic        req_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    irq_level_sel u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .level_i      (level_i),
        .sync_valid_i (sync_valid_i),
        .sync_tt_i    (sync_tt_i),
        .ack_i        (ack_i),
        .tt_o         (tt_o),
        .req_o        (req_o)
    );

    // {req tag, ack, sync_valid, sync_tt, level, expected tt, expected req}
    localparam int NV = 22;
    localparam logic [38:0] VEC [NV] = '{
        {4'd2, 1'b0, 1'b0, 8'h00, 16'h0000, 8'h00, 1'b0}, // R2 nothing pending
        {4'd2, 1'b0, 1'b0, 8'h00, 16'h0002, 8'h11, 1'b1}, // R2 R3 lowest level
        {4'd2, 1'b0, 1'b0, 8'h00, 16'h0006, 8'h12, 1'b1}, // R2 higher wins
        {4'd2, 1'b0, 1'b0, 8'h00, 16'h8006, 8'h1F, 1'b1}, // R2 top level
        {4'd2, 1'b0, 1'b0, 8'h00, 16'h0104, 8'h18, 1'b1}, // R2 moves down
        {4'd5, 1'b0, 1'b0, 8'h00, 16'h0001, 8'h18, 1'b1}, // R5 bit0 over ext
        {4'd4, 1'b0, 1'b0, 8'h00, 16'h0000, 8'h00, 1'b0}, // R4 drop
        {4'd5, 1'b0, 1'b0, 8'h00, 16'h0001, 8'h00, 1'b0}, // R5 bit0 over empty
        {4'd2, 1'b0, 1'b0, 8'h00, 16'h0020, 8'h15, 1'b1}, // R2
        {4'd6, 1'b0, 1'b1, 8'h2A, 16'h0020, 8'h2A, 1'b1}, // R6 sync over ext
        {4'd7, 1'b0, 1'b0, 8'h00, 16'hFFFF, 8'h2A, 1'b1}, // R7 levels ignored
        {4'd7, 1'b0, 1'b0, 8'h00, 16'h0000, 8'h2A, 1'b1}, // R7 idle ignored
        {4'd7, 1'b0, 1'b1, 8'h07, 16'h0000, 8'h2A, 1'b1}, // R7 sync ignored
        {4'd8, 1'b1, 1'b0, 8'h00, 16'h0400, 8'h00, 1'b0}, // R8 ack clears
        {4'd8, 1'b0, 1'b0, 8'h00, 16'h0400, 8'h1A, 1'b1}, // R8 re-evaluate
        {4'd9, 1'b0, 1'b1, 8'h13, 16'h0400, 8'h1A, 1'b1}, // R9 ext-range sync
        {4'd9, 1'b0, 1'b1, 8'h00, 16'h0000, 8'h00, 1'b0}, // R9 zero sync, R4
        {4'd6, 1'b0, 1'b1, 8'h09, 16'h0000, 8'h09, 1'b0}, // R6 sync from empty
        {4'd7, 1'b0, 1'b0, 8'h00, 16'h0010, 8'h09, 1'b0}, // R7
        {4'd8, 1'b1, 1'b0, 8'h00, 16'h0010, 8'h00, 1'b0}, // R8
        {4'd3, 1'b0, 1'b0, 8'h00, 16'h0010, 8'h14, 1'b1}, // R3 raise
        {4'd8, 1'b1, 1'b1, 8'h05, 16'h0010, 8'h00, 1'b0}  // R8 ack over sync
    };

    task automatic check(input int rq, input logic [7:0] ett, input logic ereq);
        n_checks++;
        if (tt_o !== ett || req_o !== ereq) begin
            n_fail++;
            $display("FAIL R%0d: tt=%h req=%b expected tt=%h req=%b",
                     rq, tt_o, req_o, ett, ereq);
        end
    endtask

    task automatic drive(input logic a, input logic sv, input logic [7:0] st,
                         input logic [15:0] lv);
        ack_i = a; sync_valid_i = sv; sync_tt_i = st; level_i = lv;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(1, 8'h00, 1'b0); // R1 reset state
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            drive(VEC[k][34], VEC[k][33], VEC[k][32:25], VEC[k][24:9]);
            @(negedge clk);
            check(int'(VEC[k][38:35]), VEC[k][8:1], VEC[k][0]);
        end

        // R3: same level held for several cycles keeps type and request
        drive(1'b0, 1'b0, 8'h00, 16'h0010);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(3, 8'h14, 1'b1);
        end

        // R2: a lower level arriving under a higher one changes nothing
        drive(1'b0, 1'b0, 8'h00, 16'h0013);
        @(negedge clk);
        check(2, 8'h14, 1'b1);

        // R2: output is registered, change is visible only after an edge
        @(negedge clk);
        drive(1'b0, 1'b0, 8'h00, 16'h4000);
        #2 check(2, 8'h14, 1'b1);
        @(negedge clk);
        check(2, 8'h1E, 1'b1);

        // R1: reset in the middle of activity
        rst_n = 1'b0;
        @(negedge clk);
        check(1, 8'h00, 1'b0);
        @(negedge clk);
        check(1, 8'h00, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check(2, 8'h1E, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule